// File: doc/BRIEF.md
# Privilege-Filtered Performance Counter Bank

This block counts hardware events and clock cycles for profiling. It has a parameterised set of programmable event counters, 4 by default and at most 31, and one free-running 64-bit cycle counter. Each event counter has a type register. The type register names the event strobe the counter follows and carries a set of filter bits. The filter bits decide, for every exception level and security state, whether counting is allowed. The cycle counter has a filter register with the same layout.

Several gates sit in front of every increment. Counting must be allowed by the master enable in the control register, by the counter's own bit in the count-enable register, and by the filter bits for the current exception level and security state. An event counter must also see its selected strobe high. The cycle counter has one more gate: a control bit that stops it in prohibited states, which are EL2 and the secure world.

Software reaches all registers through a plain port. A write is taken on a clock edge. The read data is combinational from a separate read address.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset all counters, type registers, the cycle filter, the count-enable register and the control register read zero.
- R2: When control bit 0 (master enable) is 0, no counter increments, whatever the other registers hold.
- R3: In the count-enable register, bit n enables event counter n and bit 31 enables the cycle counter. A counter whose bit is 0 never increments.
- R4: An event counter increments by one on each enabled clock in which strobe k is high. Here k is type bits [9:0], extended by bits [15:10] only when the extension parameter is set; otherwise bits [15:10] read zero. An event number at or above the strobe count never counts.
- R5: At EL0, filter bit 30 set to 1 blocks counting, and set to 0 allows it.
- R6: At EL1, counting needs filter bit 31 = 0. In the non-secure state it also needs bit 29 to equal bit 31.
- R7: At EL2, counting needs filter bit 27 = 1. In the secure state it also needs bit 24 to differ from bit 27.
- R8: At EL3, counting needs bit 31 = 0 and bit 26 equal to bit 31.
- R9: The 64-bit cycle counter increments on every clock in which it is permitted. Its filter register (address 0x42) uses the same bit layout and rules as the type registers.
- R10: When control bit 5 is 1, the cycle counter does not count at EL2 or in the secure state. When control bit 5 is 0, those states do not stop it.
- R11: Counters wrap to zero on overflow. The cycle counter carries from its low word into its high word.
- R12: A register write to a counter in the same cycle as an increment wins: the written value is stored and that increment is lost.
- R13: Register map. Event counter n is at 0x00+n and its type register at 0x20+n. Cycle low word is at 0x40, cycle high word at 0x41, cycle filter at 0x42, count-enable at 0x43 and control at 0x44. Bits that are not implemented read zero, and so does any unmapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_stb_i | input | NUM_STB | Event strobes, one bit per event number |
| el_i | input | 2 | Current exception level, 0 to 3 |
| secure_i | input | 1 | 1 when the current state is secure |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 7 | Write address |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | 7 | Read address |
| reg_rdata_o | output | 32 | Read data, combinational from reg_raddr_i |

## Verification
A write or an increment caused by the inputs during clock cycle k shows on the read port just after edge k, since there is one register between the inputs and the read data. The bench drives every stimulus at the falling edge. A counting window lasts a known number of rising edges, and the bench then parks the block in a state that cannot count: strobes low, and EL2 non-secure with a cycle filter that blocks EL2. Only then does the driver queue an expected read. The monitor samples it a nanosecond later, so the value cannot move under the check.

// File: rtl/pcb_pkg.sv
`timescale 1ns/1ps
package pcb_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 7;

  localparam logic [ADDR_W-1:0] A_CNT_BASE  = 7'h00;
  localparam logic [ADDR_W-1:0] A_TYPE_BASE = 7'h20;
  localparam logic [ADDR_W-1:0] A_CYC_LO    = 7'h40;
  localparam logic [ADDR_W-1:0] A_CYC_HI    = 7'h41;
  localparam logic [ADDR_W-1:0] A_CYC_FLT   = 7'h42;
  localparam logic [ADDR_W-1:0] A_CNTEN     = 7'h43;
  localparam logic [ADDR_W-1:0] A_CTRL      = 7'h44;

  // filter bit positions (shared by type and cycle filter registers)
  localparam int unsigned B_P   = 31;
  localparam int unsigned B_U   = 30;
  localparam int unsigned B_NSK = 29;
  localparam int unsigned B_NSH = 27;
  localparam int unsigned B_M   = 26;
  localparam int unsigned B_SH  = 24;
  localparam logic [REG_W-1:0] FLT_MASK = 32'hED00_0000;

  localparam int unsigned B_EN     = 0;
  localparam int unsigned B_DP     = 5;
  localparam int unsigned B_CYC_EN = 31;

  typedef struct packed {
    logic p;
    logic u;
    logic nsk;
    logic nsh;
    logic m;
    logic sh;
  } flt_t;

  function automatic flt_t flt_unpack(logic [REG_W-1:0] r);
    flt_t f;
    f.p   = r[B_P];
    f.u   = r[B_U];
    f.nsk = r[B_NSK];
    f.nsh = r[B_NSH];
    f.m   = r[B_M];
    f.sh  = r[B_SH];
    return f;
  endfunction
endpackage

// File: rtl/pcb_filter.sv
`timescale 1ns/1ps
module pcb_filter
  import pcb_pkg::*;
(
  input  flt_t       flt_i,
  input  logic [1:0] el_i,
  input  logic       secure_i,
  output logic       permit_o
);
  always_comb begin
    case (el_i)
      2'd0:    permit_o = ~flt_i.u;
      2'd1:    permit_o = ~flt_i.p & (secure_i | (flt_i.nsk == flt_i.p));
      2'd2:    permit_o = flt_i.nsh & (~secure_i | (flt_i.sh != flt_i.nsh));
      default: permit_o = ~flt_i.p & (flt_i.m == flt_i.p);
    endcase
  end
endmodule

// File: rtl/pcb_evt_cnt.sv
`timescale 1ns/1ps
module pcb_evt_cnt
  import pcb_pkg::*;
#(
  parameter int unsigned NUM_STB = 16,
  parameter int unsigned CNT_W   = 32,
  parameter bit          EVT_EXT = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [1:0]         el_i,
  input  logic               secure_i,
  input  logic [NUM_STB-1:0] stb_i,
  input  logic               type_we_i,
  input  logic               cnt_we_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   type_o,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam int unsigned EVT_W = EVT_EXT ? 16 : 10;
  localparam logic [REG_W-1:0] TYPE_MASK = FLT_MASK | ((32'd1 << EVT_W) - 32'd1);

  logic [REG_W-1:0] type_q;
  logic [CNT_W-1:0] cnt_q;
  logic [EVT_W-1:0] evt_sel;
  logic             hit, permit, inc;

  assign evt_sel = type_q[EVT_W-1:0];

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_STB; i++) begin
      if (evt_sel == EVT_W'(i)) hit = stb_i[i];
    end
  end

  pcb_filter i_filter (
    .flt_i   (flt_unpack(type_q)),
    .el_i    (el_i),
    .secure_i(secure_i),
    .permit_o(permit)
  );

  assign inc = en_i & permit & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (type_we_i) type_q <= wdata_i & TYPE_MASK;
      if (cnt_we_i)  cnt_q  <= wdata_i[CNT_W-1:0];
      else if (inc)  cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign type_o = type_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/pcb_cyc_cnt.sv
`timescale 1ns/1ps
module pcb_cyc_cnt
  import pcb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             dp_i,
  input  logic [1:0]       el_i,
  input  logic             secure_i,
  input  logic             flt_we_i,
  input  logic             lo_we_i,
  input  logic             hi_we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] flt_o,
  output logic [63:0]      cnt_o,
  output logic             inc_o
);
  logic [REG_W-1:0] flt_q;
  logic [63:0]      cnt_q;
  logic             permit, prohibited;

  pcb_filter i_filter (
    .flt_i   (flt_unpack(flt_q)),
    .el_i    (el_i),
    .secure_i(secure_i),
    .permit_o(permit)
  );

  assign prohibited = (el_i == 2'd2) | secure_i;
  assign inc_o      = en_i & permit & ~(dp_i & prohibited);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_q <= '0;
      cnt_q <= '0;
    end else begin
      if (flt_we_i) flt_q <= wdata_i & FLT_MASK;
      if (lo_we_i || hi_we_i)
        cnt_q <= {hi_we_i ? wdata_i : cnt_q[63:32], lo_we_i ? wdata_i : cnt_q[31:0]};
      else if (inc_o)
        cnt_q <= cnt_q + 64'd1;
    end
  end

  assign flt_o = flt_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/perf_counter_bank.sv
`timescale 1ns/1ps
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int unsigned NUM_EVT = 4,
  parameter int unsigned NUM_STB = 16,
  parameter int unsigned CNT_W   = 32,
  parameter bit          EVT_EXT = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_STB-1:0] evt_stb_i,
  input  logic [1:0]         el_i,
  input  logic               secure_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_waddr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  input  logic [ADDR_W-1:0]  reg_raddr_i,
  output logic [REG_W-1:0]   reg_rdata_o
);
  logic               ctrl_en_q, ctrl_dp_q, cnten_cyc_q;
  logic [NUM_EVT-1:0] cnten_evt_q;
  logic [NUM_EVT-1:0] cnt_we;
  logic [REG_W-1:0]   type_a [NUM_EVT];
  logic [CNT_W-1:0]   cnt_a  [NUM_EVT];
  logic [REG_W-1:0]   cyc_flt;
  logic [63:0]        cyc_cnt;
  logic               cyc_inc, cyc_lo_we, cyc_hi_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q   <= 1'b0;
      ctrl_dp_q   <= 1'b0;
      cnten_cyc_q <= 1'b0;
      cnten_evt_q <= '0;
    end else if (reg_we_i) begin
      if (reg_waddr_i == A_CTRL) begin
        ctrl_en_q <= reg_wdata_i[B_EN];
        ctrl_dp_q <= reg_wdata_i[B_DP];
      end
      if (reg_waddr_i == A_CNTEN) begin
        cnten_cyc_q <= reg_wdata_i[B_CYC_EN];
        cnten_evt_q <= reg_wdata_i[NUM_EVT-1:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    logic type_we;
    assign type_we   = reg_we_i & (reg_waddr_i == A_TYPE_BASE + ADDR_W'(g));
    assign cnt_we[g] = reg_we_i & (reg_waddr_i == A_CNT_BASE + ADDR_W'(g));

    pcb_evt_cnt #(
      .NUM_STB(NUM_STB),
      .CNT_W  (CNT_W),
      .EVT_EXT(EVT_EXT)
    ) i_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (ctrl_en_q & cnten_evt_q[g]),
      .el_i     (el_i),
      .secure_i (secure_i),
      .stb_i    (evt_stb_i),
      .type_we_i(type_we),
      .cnt_we_i (cnt_we[g]),
      .wdata_i  (reg_wdata_i),
      .type_o   (type_a[g]),
      .cnt_o    (cnt_a[g])
    );
  end

  assign cyc_lo_we = reg_we_i & (reg_waddr_i == A_CYC_LO);
  assign cyc_hi_we = reg_we_i & (reg_waddr_i == A_CYC_HI);

  pcb_cyc_cnt i_cyc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctrl_en_q & cnten_cyc_q),
    .dp_i    (ctrl_dp_q),
    .el_i    (el_i),
    .secure_i(secure_i),
    .flt_we_i(reg_we_i & (reg_waddr_i == A_CYC_FLT)),
    .lo_we_i (cyc_lo_we),
    .hi_we_i (cyc_hi_we),
    .wdata_i (reg_wdata_i),
    .flt_o   (cyc_flt),
    .cnt_o   (cyc_cnt),
    .inc_o   (cyc_inc)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_raddr_i)
      A_CYC_LO:  reg_rdata_o = cyc_cnt[31:0];
      A_CYC_HI:  reg_rdata_o = cyc_cnt[63:32];
      A_CYC_FLT: reg_rdata_o = cyc_flt;
      A_CNTEN: begin
        reg_rdata_o[B_CYC_EN]    = cnten_cyc_q;
        reg_rdata_o[NUM_EVT-1:0] = cnten_evt_q;
      end
      A_CTRL: begin
        reg_rdata_o[B_EN] = ctrl_en_q;
        reg_rdata_o[B_DP] = ctrl_dp_q;
      end
      default: ;
    endcase
    for (int i = 0; i < NUM_EVT; i++) begin
      if (reg_raddr_i == A_CNT_BASE + ADDR_W'(i))  reg_rdata_o[CNT_W-1:0] = cnt_a[i];
      if (reg_raddr_i == A_TYPE_BASE + ADDR_W'(i)) reg_rdata_o = type_a[i];
    end
  end
endmodule

// File: rtl/pcb_checker.sv
`timescale 1ns/1ps
module pcb_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_en_i,
  input logic             ctrl_dp_i,
  input logic             cnten_cyc_i,
  input logic [1:0]       el_i,
  input logic             secure_i,
  input logic             cyc_inc_i,
  input logic             cyc_lo_we_i,
  input logic             cyc_hi_we_i,
  input logic [63:0]      cyc_cnt_i,
  input logic [31:0]      wdata_i,
  input logic             evt0_we_i,
  input logic [CNT_W-1:0] evt0_cnt_i
);
  // R2
  master_off_cyc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_en_i && !cyc_lo_we_i && !cyc_hi_we_i) |=> $stable(cyc_cnt_i));

  // R2
  master_off_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_en_i && !evt0_we_i) |=> $stable(evt0_cnt_i));

  // R3
  cyc_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnten_cyc_i && !cyc_lo_we_i && !cyc_hi_we_i) |=> $stable(cyc_cnt_i));

  // R10
  prohibit_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_dp_i && (el_i == 2'd2 || secure_i) && !cyc_lo_we_i && !cyc_hi_we_i)
      |=> $stable(cyc_cnt_i));

  // R9 R11
  cyc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_inc_i && !cyc_lo_we_i && !cyc_hi_we_i) |=> cyc_cnt_i == $past(cyc_cnt_i) + 64'd1);

  // R12
  write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_lo_we_i && !cyc_hi_we_i) |=> cyc_cnt_i[31:0] == $past(wdata_i));
endmodule

bind perf_counter_bank pcb_checker #(.CNT_W(CNT_W)) i_pcb_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctrl_en_i  (ctrl_en_q),
  .ctrl_dp_i  (ctrl_dp_q),
  .cnten_cyc_i(cnten_cyc_q),
  .el_i       (el_i),
  .secure_i   (secure_i),
  .cyc_inc_i  (cyc_inc),
  .cyc_lo_we_i(cyc_lo_we),
  .cyc_hi_we_i(cyc_hi_we),
  .cyc_cnt_i  (cyc_cnt),
  .wdata_i    (reg_wdata_i),
  .evt0_we_i  (cnt_we[0]),
  .evt0_cnt_i (cnt_a[0])
);

// File: tb/test_perf_counter_bank.sv
`timescale 1ns/1ps
module test_perf_counter_bank;
  localparam logic [6:0] A_CNT0 = 7'h00, A_CNT1 = 7'h01, A_TYPE0 = 7'h20, A_TYPE1 = 7'h21;
  localparam logic [6:0] A_CLO = 7'h40, A_CHI = 7'h41, A_CFLT = 7'h42, A_EN = 7'h43, A_CTL = 7'h44;
  localparam logic [31:0] F_P = 32'h8000_0000, F_U = 32'h4000_0000, F_NSK = 32'h2000_0000;
  localparam logic [31:0] F_NSH = 32'h0800_0000, F_M = 32'h0400_0000, F_SH = 32'h0100_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] stb = '0;
  logic [1:0]  el = 2'd2;
  logic        sec = 1'b0;
  logic        we = 1'b0;
  logic [6:0]  waddr = '0, raddr = '0;
  logic [31:0] wdata = '0, rdata;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [31:0] exp0;

  typedef struct {
    logic [6:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  event chk_done;

  always #2.5 clk = ~clk;

  perf_counter_bank i_perf_counter_bank (
    .clk_i(clk), .rst_ni(rst_n), .evt_stb_i(stb), .el_i(el), .secure_i(sec),
    .reg_we_i(we), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
    .reg_raddr_i(raddr), .reg_rdata_o(rdata)
  );

  // monitor: owns the read address
  initial begin
    forever begin
      item_t it;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      raddr = it.addr;
      #1;
      n_run++;
      if (rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr %h actual %h expected %h", it.tag, it.addr, rdata, it.exp);
      end
      ->chk_done;
    end
  end

  task automatic expect_rd(input logic [6:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(chk_done);
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic run_stb(input int idx, input int n);
    @(negedge clk);
    stb[idx] = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    stb = '0;
  endtask

  task automatic run_state(input logic [1:0] e, input logic s, input int n);
    @(negedge clk);
    el = e; sec = s;
    repeat (n) @(posedge clk);
    @(negedge clk);
    el = 2'd2; sec = 1'b0;
  endtask

  task automatic scen(input logic [31:0] flags, input logic [1:0] e, input logic s,
                      input bit permit, input string tag);
    wr(A_TYPE0, flags | 32'd3);
    el = e; sec = s;
    run_stb(3, 4);
    if (permit) exp0 = exp0 + 32'd4;
    expect_rd(A_CNT0, exp0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_rd(A_CNT0, 32'd0, "R1 cnt0");
    expect_rd(A_TYPE0, 32'd0, "R1 type0");
    expect_rd(A_CLO, 32'd0, "R1 cyc lo");
    expect_rd(A_CHI, 32'd0, "R1 cyc hi");
    expect_rd(A_CFLT, 32'd0, "R1 cyc flt");
    expect_rd(A_EN, 32'd0, "R1 cnten");
    expect_rd(A_CTL, 32'd0, "R1 ctrl");

    // R13 masking and unmapped read
    wr(A_EN, 32'hFFFF_FFFF);
    expect_rd(A_EN, 32'h8000_000F, "R13 cnten mask");
    wr(A_CTL, 32'hFFFF_FFFF);
    expect_rd(A_CTL, 32'h0000_0021, "R13 ctrl mask");
    expect_rd(7'h7F, 32'd0, "R13 unmapped");
    wr(A_EN, 32'h0000_0003);
    wr(A_CTL, 32'h0000_0001);

    // R4 extension bits reserved by default
    wr(A_TYPE0, 32'h0000_FC03);
    expect_rd(A_TYPE0, 32'h0000_0003, "R4 ext bits read zero");

    // filter scenarios on counter 0, strobe 3
    exp0 = 32'd0;
    scen(32'd0,       2'd0, 1'b0, 1'b1, "R5 el0 allowed");
    scen(F_U,         2'd0, 1'b0, 1'b0, "R5 el0 blocked");
    scen(32'd0,       2'd1, 1'b0, 1'b1, "R6 ns el1 allowed");
    scen(F_NSK,       2'd1, 1'b0, 1'b0, "R6 ns el1 nsk differs");
    scen(F_NSK,       2'd1, 1'b1, 1'b1, "R6 s el1 ignores nsk");
    scen(F_P,         2'd1, 1'b1, 1'b0, "R6 s el1 p set");
    scen(F_P | F_NSK, 2'd1, 1'b0, 1'b0, "R6 ns el1 p set");
    scen(F_NSH,       2'd2, 1'b0, 1'b1, "R7 ns el2 allowed");
    scen(32'd0,       2'd2, 1'b0, 1'b0, "R7 ns el2 nsh clear");
    scen(F_NSH,       2'd2, 1'b1, 1'b1, "R7 s el2 sh differs");
    scen(F_NSH | F_SH,2'd2, 1'b1, 1'b0, "R7 s el2 sh equal");
    scen(32'd0,       2'd3, 1'b1, 1'b1, "R8 el3 allowed");
    scen(F_M,         2'd3, 1'b1, 1'b0, "R8 el3 m differs");
    scen(F_P | F_M,   2'd3, 1'b1, 1'b0, "R8 el3 p set");
    el = 2'd0; sec = 1'b0;
    wr(A_TYPE0, 32'd3);

    // R4 event selection
    wr(A_TYPE1, 32'd7);
    run_stb(7, 5);
    expect_rd(A_CNT1, 32'd5, "R4 cnt1 follows strobe 7");
    expect_rd(A_CNT0, exp0, "R4 cnt0 ignores strobe 7");
    wr(A_TYPE1, 32'd20);
    run_stb(4, 3);
    expect_rd(A_CNT1, 32'd5, "R4 event beyond strobe count");

    // R3 per-counter enable
    wr(A_EN, 32'h0000_0002);
    run_stb(3, 3);
    expect_rd(A_CNT0, exp0, "R3 cnt0 disabled");
    wr(A_EN, 32'h0000_0003);

    // R2 master enable
    wr(A_CTL, 32'h0000_0020);
    run_stb(3, 3);
    expect_rd(A_CNT0, exp0, "R2 master off");
    wr(A_CTL, 32'h0000_0001);

    // R12 write beats increment
    @(negedge clk);
    stb[3] = 1'b1; we = 1'b1; waddr = A_CNT0; wdata = 32'd100;
    @(negedge clk);
    stb = '0; we = 1'b0;
    expect_rd(A_CNT0, 32'd100, "R12 event write wins");

    // R11 event wrap
    wr(A_CNT0, 32'hFFFF_FFFF);
    run_stb(3, 2);
    expect_rd(A_CNT0, 32'd1, "R11 event wrap");

    // cycle counter, parked at ns EL2 with filter 0
    el = 2'd2; sec = 1'b0;
    wr(A_EN, 32'h8000_0003);
    expect_rd(A_CLO, 32'd0, "R7 cycle parked at el2");
    run_state(2'd1, 1'b0, 5);
    expect_rd(A_CLO, 32'd5, "R9 cycle counts");

    // R10 prohibition override
    wr(A_CTL, 32'h0000_0021);
    run_state(2'd1, 1'b1, 4);
    expect_rd(A_CLO, 32'd5, "R10 stopped in secure");
    run_state(2'd0, 1'b0, 2);
    expect_rd(A_CLO, 32'd7, "R10 runs when allowed");
    wr(A_CTL, 32'h0000_0001);
    run_state(2'd1, 1'b1, 4);
    expect_rd(A_CLO, 32'd11, "R10 dp clear runs in secure");

    // R9 cycle filter layout
    wr(A_CFLT, F_U | 32'h0000_FFFF);
    expect_rd(A_CFLT, F_U, "R9 cycle filter readback");
    run_state(2'd0, 1'b0, 3);
    expect_rd(A_CLO, 32'd11, "R9 cycle blocked at el0");
    wr(A_CFLT, 32'd0);

    // R3 cycle enable bit
    wr(A_EN, 32'h0000_0003);
    run_state(2'd1, 1'b0, 3);
    expect_rd(A_CLO, 32'd11, "R3 cycle disabled");
    wr(A_EN, 32'h8000_0003);

    // R2 master enable on cycle
    wr(A_CTL, 32'd0);
    run_state(2'd1, 1'b0, 3);
    expect_rd(A_CLO, 32'd11, "R2 cycle master off");
    wr(A_CTL, 32'd1);

    // R11 carry and wrap
    wr(A_CLO, 32'hFFFF_FFFF);
    wr(A_CHI, 32'd0);
    run_state(2'd1, 1'b0, 1);
    expect_rd(A_CLO, 32'd0, "R11 carry lo");
    expect_rd(A_CHI, 32'd1, "R11 carry hi");
    wr(A_CLO, 32'hFFFF_FFFF);
    wr(A_CHI, 32'hFFFF_FFFF);
    run_state(2'd1, 1'b0, 1);
    expect_rd(A_CLO, 32'd0, "R11 wrap lo");
    expect_rd(A_CHI, 32'd0, "R11 wrap hi");

    // R12 cycle write wins
    @(negedge clk);
    el = 2'd1; we = 1'b1; waddr = A_CHI; wdata = 32'd5;
    @(negedge clk);
    el = 2'd2; we = 1'b0;
    expect_rd(A_CLO, 32'd0, "R12 cycle lo held");
    expect_rd(A_CHI, 32'd5, "R12 cycle hi written");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule